// File: doc/BRIEF.md
# Home-Node Sharer-Vector Coherence Directory

This block is the home-side coherence controller for a small distributed shared-memory machine. It holds a directory entry for every memory block it owns and a small internal array with the block data. Each entry is a three-way state: no cached copy, read-only copies, or one writable copy. Each entry also keeps a presence vector with one bit per processor. Cache controllers send it read misses, write misses and write-backs, each tagged with the sender's processor number and a block number. The controller answers with point-to-point messages: invalidations, fetches and fetch-with-invalidate orders to specific processors, and data replies to the requester. It never broadcasts.

Requests are taken one at a time from an in-order request channel. A miss that finds the block held writable makes the controller order the owner to return the data. The controller then waits for that write-back, takes nothing else in the meantime, and only then replies to the requester. Invalidations to the other readers go out one per cycle, lowest processor number first, ahead of the reply.

FSM states: IDLE (accept and decode a request), INVAL (send one invalidation per cycle), FETCH (send the fetch order), WAIT (hold until the owner's write-back arrives), REPLY (send the data reply). Transitions: IDLE to REPLY on a miss served from memory. IDLE to INVAL on a write miss that finds other readers. IDLE to FETCH on a miss to a writable block. IDLE to IDLE on a write-back. INVAL to REPLY after the last invalidation. FETCH to WAIT. WAIT to REPLY on the owner's write-back. REPLY to IDLE.

Top module: `coh_home_dir`

## Requirements
- R1: After reset every block has state Uncached and an empty presence vector, memory block b holds (37*b+5) mod 2^DW, req_ready is 1 and msg_valid is 0.
- R2: A read miss to an Uncached or Shared block produces one reply carrying the memory data to the requester. The state becomes Shared, and the requester is added to the presence vector without removing anyone.
- R3: A write miss to an Uncached block produces only a reply carrying the memory data. The presence vector becomes just the requester, and the state becomes Exclusive.
- R4: A write miss to a Shared block sends one invalidation per cycle to each present processor other than the requester, in ascending processor order, then the memory-data reply. The block becomes Exclusive to the requester.
- R5: A read miss to an Exclusive block sends a fetch to the owner and then waits for the owner's write-back. It stores the returned data in memory and replies with that data. The presence vector becomes owner plus requester, and the state becomes Shared.
- R6: A write miss to an Exclusive block sends a fetch-and-invalidate to the owner, then replies with the data the owner returns. Memory is left unchanged, and the block stays Exclusive with only the requester present.
- R7: A write-back from the present owner of an Exclusive block stores its data in memory and makes the block Uncached with an empty vector. It sends no message.
- R8: A write-back from a processor that does not hold the block Exclusive, or a request of kind 3, is consumed with no message and no change to directory or memory.
- R9: While waiting for the owner's write-back, req_ready is 0 for every request except a write-back from that owner for that block. In IDLE, req_ready is 1.
- R10: Request kinds are encoded as read miss 0, write miss 1, write-back 2. Message kinds are encoded as invalidate 0, fetch 1, fetch-and-invalidate 2, data reply 3. msg_blk always carries the block being served.
- R11: An Exclusive block always has exactly one presence bit set, and an Uncached block has none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request taken at this edge when valid |
| req_kind | input | 2 | Request kind (R10) |
| req_node | input | NW = clog2(NPROC) | Sending processor |
| req_blk | input | BW = clog2(NBLK) | Block number |
| req_data | input | DW | Write-back data |
| msg_valid | output | 1 | Outgoing message present this cycle |
| msg_kind | output | 2 | Message kind (R10) |
| msg_node | output | NW | Destination processor |
| msg_blk | output | BW | Block number of the message |
| msg_data | output | DW | Reply data (zero for other kinds) |

## Verification
The bench keeps its own directory model and drives directed sequences and a long pseudo-random sweep over four processors and four blocks. The sweep covers every state-by-request pairing. One corner case is a write miss by a processor that is itself a reader: a design that forgot to mask the requester would invalidate it, and one that picked readers in the wrong order would send the invalidations out of sequence. During the wait for a write-back the bench offers a competing read. A design without the stall would take it and serve stale memory. Write-backs from non-owners check that a design which fails to confirm ownership does not corrupt memory or drop the block to Uncached. The bench also follows each transition to Exclusive and to Uncached with further misses, and a stale presence vector would show up there as extra or missing invalidations.

// File: rtl/coh_dir_pkg.sv
package coh_dir_pkg;

    typedef enum logic [1:0] {
        DIR_UNC = 2'd0,
        DIR_SHR = 2'd1,
        DIR_EXC = 2'd2
    } dir_state_e;

    typedef enum logic [1:0] {
        RQ_READ  = 2'd0,
        RQ_WRITE = 2'd1,
        RQ_WBACK = 2'd2,
        RQ_NONE  = 2'd3
    } req_kind_e;

    typedef enum logic [1:0] {
        MS_INVAL     = 2'd0,
        MS_FETCH     = 2'd1,
        MS_FETCH_INV = 2'd2,
        MS_REPLY     = 2'd3
    } msg_kind_e;

    typedef enum logic [2:0] {
        S_IDLE  = 3'd0,
        S_INVAL = 3'd1,
        S_FETCH = 3'd2,
        S_WAIT  = 3'd3,
        S_REPLY = 3'd4
    } fsm_state_e;

endpackage

// File: rtl/coh_lowbit_pick.sv
module coh_lowbit_pick #(
    parameter int N = 4,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  vec,
    output logic [N-1:0]  grant,
    output logic [IW-1:0] idx
);

    logic [N:0] seen;

    assign seen[0] = 1'b0;

    for (genvar i = 0; i < N; i++) begin : g_chain
        assign grant[i]  = vec[i] & ~seen[i];
        assign seen[i+1] = seen[i] | vec[i];
    end

    always_comb begin
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (grant[i]) begin
                idx = idx | IW'(i);
            end
        end
    end

endmodule

// File: rtl/coh_dir_store.sv
module coh_dir_store
    import coh_dir_pkg::*;
#(
    parameter int NPROC = 4,
    parameter int NBLK  = 8,
    parameter int DW    = 8,
    localparam int BW   = $clog2(NBLK)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [BW-1:0]    addr,
    output dir_state_e       rd_st,
    output logic [NPROC-1:0] rd_sh,
    output logic [DW-1:0]    rd_mem,
    input  logic             dir_we,
    input  dir_state_e       wr_st,
    input  logic [NPROC-1:0] wr_sh,
    input  logic             mem_we,
    input  logic [DW-1:0]    mem_wd
);

    dir_state_e       st_q  [NBLK];
    logic [NPROC-1:0] sh_q  [NBLK];
    logic [DW-1:0]    mem_q [NBLK];

    assign rd_st  = st_q[addr];
    assign rd_sh  = sh_q[addr];
    assign rd_mem = mem_q[addr];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int b = 0; b < NBLK; b++) begin
                st_q[b]  <= DIR_UNC;
                sh_q[b]  <= '0;
                mem_q[b] <= DW'(37 * b + 5);
            end
        end else begin
            if (dir_we) begin
                st_q[addr] <= wr_st;
                sh_q[addr] <= wr_sh;
            end
            if (mem_we) begin
                mem_q[addr] <= mem_wd;
            end
        end
    end

    for (genvar g = 0; g < NBLK; g++) begin : g_inv
        // R11: a writable block has a single owner
        assert_excl_single_owner_R11: assert property (@(posedge clk) disable iff (!rst_n)
            (st_q[g] == DIR_EXC) |-> ($countones(sh_q[g]) == 1));
        // R11: an uncached block has nobody present
        assert_unc_vector_empty_R11: assert property (@(posedge clk) disable iff (!rst_n)
            (st_q[g] == DIR_UNC) |-> ($countones(sh_q[g]) == 0));
    end

endmodule

// File: rtl/coh_home_dir.sv
module coh_home_dir
    import coh_dir_pkg::*;
#(
    parameter int NPROC = 4,
    parameter int NBLK  = 8,
    parameter int DW    = 8,
    localparam int NW   = $clog2(NPROC),
    localparam int BW   = $clog2(NBLK)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [1:0]    req_kind,
    input  logic [NW-1:0] req_node,
    input  logic [BW-1:0] req_blk,
    input  logic [DW-1:0] req_data,
    output logic          msg_valid,
    output logic [1:0]    msg_kind,
    output logic [NW-1:0] msg_node,
    output logic [BW-1:0] msg_blk,
    output logic [DW-1:0] msg_data
);

    fsm_state_e state, nxt;

    logic [1:0]       cur_kind;
    logic [NW-1:0]    cur_node;
    logic [BW-1:0]    cur_blk;
    logic [NPROC-1:0] cur_bit;
    logic [DW-1:0]    rsp_data;
    logic [NPROC-1:0] inv_mask;
    logic [NW-1:0]    owner_idx_q;
    logic [NPROC-1:0] owner_oh_q;

    logic [NPROC-1:0] req_bit;
    logic [BW-1:0]    addr;
    dir_state_e       rd_st;
    logic [NPROC-1:0] rd_sh;
    logic [DW-1:0]    rd_mem;
    logic             dir_we;
    dir_state_e       wr_st;
    logic [NPROC-1:0] wr_sh;
    logic             mem_we;
    logic             ld_req;
    logic             wb_match;

    logic [NPROC-1:0] inv_grant;
    logic [NW-1:0]    inv_idx;
    logic [NPROC-1:0] inv_rest;
    logic [NPROC-1:0] own_grant;
    logic [NW-1:0]    own_idx;

    assign req_bit = {{(NPROC-1){1'b0}}, 1'b1} << req_node;
    assign cur_bit = {{(NPROC-1){1'b0}}, 1'b1} << cur_node;
    assign addr    = (state == S_IDLE) ? req_blk : cur_blk;

    coh_dir_store #(.NPROC(NPROC), .NBLK(NBLK), .DW(DW)) i_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .addr   (addr),
        .rd_st  (rd_st),
        .rd_sh  (rd_sh),
        .rd_mem (rd_mem),
        .dir_we (dir_we),
        .wr_st  (wr_st),
        .wr_sh  (wr_sh),
        .mem_we (mem_we),
        .mem_wd (req_data)
    );

    coh_lowbit_pick #(.N(NPROC)) i_inv_pick (
        .vec   (inv_mask),
        .grant (inv_grant),
        .idx   (inv_idx)
    );

    coh_lowbit_pick #(.N(NPROC)) i_own_pick (
        .vec   (rd_sh),
        .grant (own_grant),
        .idx   (own_idx)
    );

    assign inv_rest = inv_mask & ~inv_grant;
    assign wb_match = req_valid && (req_kind == RQ_WBACK) && (req_bit == owner_oh_q)
                      && (req_blk == cur_blk);
    assign req_ready = (state == S_IDLE) || ((state == S_WAIT) && wb_match);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // next state and directory updates
    always_comb begin
        nxt    = state;
        dir_we = 1'b0;
        wr_st  = rd_st;
        wr_sh  = rd_sh;
        mem_we = 1'b0;
        ld_req = 1'b0;
        unique case (state)
            S_IDLE: begin
                if (req_valid) begin
                    ld_req = 1'b1;
                    if (req_kind == RQ_READ) begin
                        if (rd_st == DIR_EXC) begin
                            nxt = S_FETCH;
                        end else begin
                            dir_we = 1'b1;
                            wr_st  = DIR_SHR;
                            wr_sh  = rd_sh | req_bit;
                            nxt    = S_REPLY;
                        end
                    end else if (req_kind == RQ_WRITE) begin
                        if (rd_st == DIR_EXC) begin
                            nxt = S_FETCH;
                        end else begin
                            dir_we = 1'b1;
                            wr_st  = DIR_EXC;
                            wr_sh  = req_bit;
                            if ((rd_st == DIR_SHR) && ((rd_sh & ~req_bit) != '0)) begin
                                nxt = S_INVAL;
                            end else begin
                                nxt = S_REPLY;
                            end
                        end
                    end else if ((req_kind == RQ_WBACK) && (rd_st == DIR_EXC)
                                 && ((rd_sh & req_bit) != '0)) begin
                        dir_we = 1'b1;
                        wr_st  = DIR_UNC;
                        wr_sh  = '0;
                        mem_we = 1'b1;
                    end
                end
            end
            S_INVAL: begin
                if (inv_rest == '0) begin
                    nxt = S_REPLY;
                end
            end
            S_FETCH: begin
                nxt = S_WAIT;
            end
            S_WAIT: begin
                if (wb_match) begin
                    dir_we = 1'b1;
                    if (cur_kind == RQ_READ) begin
                        wr_st  = DIR_SHR;
                        wr_sh  = owner_oh_q | cur_bit;
                        mem_we = 1'b1;
                    end else begin
                        wr_st  = DIR_EXC;
                        wr_sh  = cur_bit;
                    end
                    nxt = S_REPLY;
                end
            end
            S_REPLY: begin
                nxt = S_IDLE;
            end
            default: begin
                nxt = S_IDLE;
            end
        endcase
    end

    // latched request and working registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_kind    <= '0;
            cur_node    <= '0;
            cur_blk     <= '0;
            rsp_data    <= '0;
            inv_mask    <= '0;
            owner_idx_q <= '0;
            owner_oh_q  <= '0;
        end else begin
            if (ld_req) begin
                cur_kind    <= req_kind;
                cur_node    <= req_node;
                cur_blk     <= req_blk;
                rsp_data    <= rd_mem;
                inv_mask    <= rd_sh & ~req_bit;
                owner_idx_q <= own_idx;
                owner_oh_q  <= own_grant;
            end else if (state == S_INVAL) begin
                inv_mask <= inv_rest;
            end else if ((state == S_WAIT) && wb_match) begin
                rsp_data <= req_data;
            end
        end
    end

    // outgoing message
    always_comb begin
        msg_valid = 1'b0;
        msg_kind  = MS_INVAL;
        msg_node  = '0;
        msg_blk   = cur_blk;
        msg_data  = '0;
        unique case (state)
            S_INVAL: begin
                msg_valid = 1'b1;
                msg_kind  = MS_INVAL;
                msg_node  = inv_idx;
            end
            S_FETCH: begin
                msg_valid = 1'b1;
                msg_kind  = (cur_kind == RQ_READ) ? MS_FETCH : MS_FETCH_INV;
                msg_node  = owner_idx_q;
            end
            S_REPLY: begin
                msg_valid = 1'b1;
                msg_kind  = MS_REPLY;
                msg_node  = cur_node;
                msg_data  = rsp_data;
            end
            default: begin
            end
        endcase
    end

    // R4: the requester never receives its own invalidation
    assert_inval_skips_requester_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && (msg_kind == MS_INVAL)) |-> (msg_node != cur_node));

    // R9: competing requests are held off during the write-back wait
    assert_stall_during_wait_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == S_WAIT) && req_valid && (req_kind != RQ_WBACK)) |-> !req_ready);

    // R5: a fetch order is followed by a silent wait cycle
    assert_fetch_then_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && (msg_kind != MS_INVAL) && (msg_kind != MS_REPLY)) |=> !msg_valid);

    // R6: the reply after a write-back carries the returned data
    assert_reply_forwards_wb_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == S_WAIT) && req_ready) |=>
            (msg_valid && (msg_kind == MS_REPLY) && (msg_data == $past(req_data))));

endmodule

// File: tb/test_coh_home_dir.sv
`timescale 1ns/1ps
module test_coh_home_dir;

    localparam int NP = 4;
    localparam int NB = 4;
    localparam int DW = 8;
    localparam int NW = 2;
    localparam int BW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [1:0]    req_kind = '0;
    logic [NW-1:0] req_node = '0;
    logic [BW-1:0] req_blk = '0;
    logic [DW-1:0] req_data = '0;
    logic          msg_valid;
    logic [1:0]    msg_kind;
    logic [NW-1:0] msg_node;
    logic [BW-1:0] msg_blk;
    logic [DW-1:0] msg_data;

    always #4 clk = ~clk;

    coh_home_dir #(.NPROC(NP), .NBLK(NB), .DW(DW)) i_coh_home_dir (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_kind  (req_kind),
        .req_node  (req_node),
        .req_blk   (req_blk),
        .req_data  (req_data),
        .msg_valid (msg_valid),
        .msg_kind  (msg_kind),
        .msg_node  (msg_node),
        .msg_blk   (msg_blk),
        .msg_data  (msg_data)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    int            m_st  [NB];
    logic [NP-1:0] m_sh  [NB];
    logic [DW-1:0] m_mem [NB];

    int            ek [16];
    int            en [16];
    logic [DW-1:0] ed [16];
    int            ne;
    int            salt = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int owner_of(input int b);
        for (int i = 0; i < NP; i++) begin
            if (m_sh[b][i]) return i;
        end
        return 0;
    endfunction

    task automatic add_msg(input int k, input int n, input logic [DW-1:0] d);
        ek[ne] = k;
        en[ne] = n;
        ed[ne] = d;
        ne++;
    endtask

    // kinds: 0 read miss, 1 write miss, 2 write-back, 3 unused
    task automatic txn(input int k, input int n, input int b, input logic [DW-1:0] d);
        int own;
        bit excl;
        string rtag;
        logic [DW-1:0] wbd;
        ne   = 0;
        own  = owner_of(b);
        excl = (m_st[b] == 2);
        wbd  = DW'(8'h90 + n * 16 + b * 3 + salt);
        salt++;
        if (k == 0) begin
            rtag = excl ? "R5" : "R2";
            if (excl) begin
                add_msg(1, own, '0);
                add_msg(3, n, wbd);
                m_mem[b] = wbd;
            end else begin
                add_msg(3, n, m_mem[b]);
            end
            m_sh[b] = m_sh[b] | NP'(1 << n);
            m_st[b] = 1;
        end else if (k == 1) begin
            if (excl) begin
                rtag = "R6 R11";
                add_msg(2, own, '0);
                add_msg(3, n, wbd);
            end else begin
                rtag = (m_st[b] == 1) ? "R4" : "R3 R11";
                if (m_st[b] == 1) begin
                    for (int i = 0; i < NP; i++) begin
                        if (m_sh[b][i] && i != n) add_msg(0, i, '0);
                    end
                end
                add_msg(3, n, m_mem[b]);
            end
            m_sh[b] = NP'(1 << n);
            m_st[b] = 2;
        end else begin
            if (k == 2 && excl && m_sh[b][n]) begin
                rtag = "R7";
                m_mem[b] = d;
                m_st[b]  = 0;
                m_sh[b]  = '0;
            end else begin
                rtag = "R8";
            end
        end

        @(negedge clk);
        req_valid = 1'b1;
        req_kind  = 2'(k);
        req_node  = NW'(n);
        req_blk   = BW'(b);
        req_data  = d;
        #1;
        chk(req_ready == 1'b1, "R9 idle accepts request", int'(req_ready), 1);
        @(posedge clk);
        for (int i = 0; i < ne; i++) begin
            int t;
            t = 0;
            @(negedge clk);
            req_valid = 1'b0;
            #1;
            while (!msg_valid && t < 20) begin
                @(negedge clk);
                #1;
                t++;
            end
            chk(msg_valid && msg_kind == 2'(ek[i]), {rtag, " R10 message kind"},
                msg_valid ? int'(msg_kind) : -1, ek[i]);
            chk(msg_node == NW'(en[i]) && msg_blk == BW'(b), {rtag, " message target"},
                int'(msg_node), en[i]);
            if (ek[i] == 3) begin
                chk(msg_data == ed[i], {rtag, " reply data"}, int'(msg_data), int'(ed[i]));
            end
            if (ek[i] == 1 || ek[i] == 2) begin
                req_valid = 1'b1;
                req_kind  = 2'd0;
                req_node  = NW'((own + 1) % NP);
                req_blk   = BW'(b);
                req_data  = '0;
                @(negedge clk);
                #1;
                chk(req_ready == 1'b0, "R9 competing request stalled", int'(req_ready), 0);
                req_kind = 2'd2;
                req_node = NW'(own);
                req_data = wbd;
                #1;
                chk(req_ready == 1'b1, "R9 owner write-back accepted", int'(req_ready), 1);
                @(posedge clk);
            end
        end
        repeat ((ne == 0) ? 3 : 1) begin
            @(negedge clk);
            req_valid = 1'b0;
            #1;
            chk(msg_valid == 1'b0, {rtag, " no further message"}, int'(msg_valid), 0);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int unsigned r;
        for (int b = 0; b < NB; b++) begin
            m_st[b]  = 0;
            m_sh[b]  = '0;
            m_mem[b] = DW'(37 * b + 5);
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        #1;
        // R1: reset state at the ports
        chk(msg_valid == 1'b0, "R1 no message after reset", int'(msg_valid), 0);
        rst_n = 1'b1;
        #1;
        chk(req_ready == 1'b1, "R1 ready after reset", int'(req_ready), 1);

        // R1 R2: first reads return the reset memory image
        for (int b = 0; b < NB; b++) txn(0, b, b, '0);

        // block 0: sharers grow, write by a reader, fetch paths, write-backs
        txn(0, 2, 0, '0);
        txn(0, 3, 0, '0);
        txn(1, 2, 0, '0);       // R4 invalidates 0 and 3
        txn(0, 1, 0, '0);       // R5 fetch from 2
        txn(1, 3, 0, '0);       // R4 invalidates 1 and 2
        txn(2, 0, 0, 8'h11);    // R8 non-owner write-back
        txn(2, 3, 0, 8'h5A);    // R7 owner write-back
        txn(0, 1, 0, '0);       // R2 sees 8'h5A
        txn(2, 1, 0, 8'h77);    // R8 write-back while Shared
        txn(1, 0, 0, '0);       // R4 invalidates 1

        // block 1: ownership moves by write misses
        txn(1, 1, 1, '0);
        txn(1, 2, 1, '0);       // R6 fetch-invalidate to 1
        txn(1, 2, 1, '0);       // R6 owner refetched by itself
        txn(3, 0, 1, 8'h33);    // R8 unused kind
        txn(2, 2, 1, 8'hC3);    // R7
        txn(1, 3, 1, '0);       // R3 from Uncached

        // sweep
        r = 32'h1234_5678;
        for (int s = 0; s < 400; s++) begin
            int sel;
            int n;
            int b;
            r = r * 32'd1103515245 + 32'd12345;
            sel = int'((r >> 8) % 6);
            n = int'((r >> 16) % NP);
            b = int'((r >> 20) % NB);
            if (sel < 2) begin
                txn(0, n, b, '0);
            end else if (sel < 4) begin
                txn(1, n, b, '0);
            end else if (sel == 4 && m_st[b] == 2) begin
                txn(2, owner_of(b), b, DW'(r >> 24));
            end else begin
                txn(2, n, b, DW'(r >> 24));
            end
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule